// File: doc/BRIEF.md
# Static Branch Resolver

The block looks at every slot of an eight-slot dispatch buffer of decoded instructions in each clock cycle. It picks the oldest branch in the buffer, computes that branch's target address and decides whether the branch is taken. The decision comes from fixed rules only. No history is kept.

An unconditional branch is always taken and is fully resolved. A conditional branch whose condition code is already valid is resolved exactly from that code. A conditional branch whose condition code is not yet available is guessed from its direction: a backward branch is guessed taken and a forward branch is guessed not taken. Such guesses are flagged as speculative so that later logic can verify them.

The decision is registered and appears one cycle after the buffer contents it was made from. A redirect request pulses in that cycle when the decision is taken. Fetch, recovery from a wrong guess and filling the buffer belong to other blocks.

Top module: `static_branch_resolver`

## Requirements
- R1: Of the slots holding a branch (slot valid and branch bit set), the one at the lowest index is chosen, and its index appears on `dec_idx`.
- R2: A slot whose valid bit is low, or whose branch bit is low, is never chosen and has no influence on the decision.
- R3: `dec_target` equals the chosen slot's PC plus its displacement sign-extended to the address width, modulo 2^AW.
- R4: A chosen branch whose conditional bit is 0 (unconditional) gives `dec_taken`=1 and `dec_spec`=0.
- R5: A chosen conditional branch with `cc_valid`=1 gives `dec_spec`=0 and `dec_taken`=1 exactly when bit `ccsel` of `cc_val` equals the slot's sense bit.
- R6: A chosen conditional branch with `cc_valid`=0 gives `dec_spec`=1. It is taken when the displacement is negative (its top bit is 1) and not taken otherwise, so a zero displacement counts as forward.
- R7: All outputs are registered one cycle after the inputs. `redir_req` is high exactly when `dec_valid` and `dec_taken` are both high. With no branch in the buffer, `dec_valid` and `redir_req` are 0.
- R8: No state other than the output register is kept, so identical buffer contents give identical decisions whatever came before.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | NENT | Slot holds a decoded instruction |
| ent_isbr | input | NENT | Slot instruction is a branch |
| ent_cond | input | NENT | Branch depends on a condition code |
| ent_sense | input | NENT | Condition bit value that makes the branch taken |
| ent_ccsel | input | NENT*CSW | Condition-code bit each slot tests |
| ent_disp | input | NENT*DW | Signed displacement for each slot |
| ent_pc | input | NENT*AW | Instruction address of each slot |
| cc_valid | input | 1 | Condition codes are current |
| cc_val | input | CCN | Condition-code bits |
| dec_valid | output | 1 | A decision is present |
| dec_idx | output | IW | Buffer index of the decided branch |
| dec_taken | output | 1 | Decision is taken |
| dec_spec | output | 1 | Decision came from the direction guess |
| dec_target | output | AW | Branch target address |
| redir_req | output | 1 | Redirect fetch to `dec_target` |

## Verification
Each slot position is tried in turn as the oldest branch. Older slots are filled with non-branches and invalid branches, and younger slots with competing branches, which separates correct priority from plain slot masking. At every position each decision class is applied: unconditional, resolved on a match, resolved on a mismatch, and unresolved with a negative, positive and zero displacement. This shows whether the resolved and guessed paths are kept apart, and places the zero displacement on the forward side. Long pseudo-random buffer contents, an empty buffer and a repeated vector test target wrap-around, the no-branch case and the absence of history.

// File: rtl/static_branch_resolver.sv
module static_branch_resolver #(
  parameter int NENT = 8,
  parameter int AW   = 32,
  parameter int DW   = 16,
  parameter int CCN  = 4,
  localparam int IW  = $clog2(NENT),
  localparam int CSW = $clog2(CCN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NENT-1:0]    ent_valid,
  input  logic [NENT-1:0]    ent_isbr,
  input  logic [NENT-1:0]    ent_cond,
  input  logic [NENT-1:0]    ent_sense,
  input  logic [NENT*CSW-1:0] ent_ccsel,
  input  logic [NENT*DW-1:0] ent_disp,
  input  logic [NENT*AW-1:0] ent_pc,
  input  logic               cc_valid,
  input  logic [CCN-1:0]     cc_val,
  output logic               dec_valid,
  output logic [IW-1:0]      dec_idx,
  output logic               dec_taken,
  output logic               dec_spec,
  output logic [AW-1:0]      dec_target,
  output logic               redir_req
);

  logic [NENT-1:0] hit;
  logic [IW-1:0]   sel;
  logic            found;
  logic [DW-1:0]   disp;
  logic [AW-1:0]   pc;
  logic [CSW-1:0]  ccsel;
  logic            cond, taken, spec;

  assign hit   = ent_valid & ent_isbr;
  assign found = |hit;

  always_comb begin
    sel = '0;
    for (int i = NENT-1; i >= 0; i--)
      if (hit[i]) sel = IW'(i);
  end

  assign disp  = ent_disp[sel*DW +: DW];
  assign pc    = ent_pc[sel*AW +: AW];
  assign ccsel = ent_ccsel[sel*CSW +: CSW];
  assign cond  = ent_cond[sel];
  assign spec  = cond & ~cc_valid;
  assign taken = ~cond | (cc_valid ? (cc_val[ccsel] == ent_sense[sel]) : disp[DW-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_idx    <= '0;
      dec_taken  <= 1'b0;
      dec_spec   <= 1'b0;
      dec_target <= '0;
      redir_req  <= 1'b0;
    end else begin
      dec_valid  <= found;
      dec_idx    <= sel;
      dec_taken  <= found & taken;
      dec_spec   <= found & spec;
      dec_target <= found ? pc + {{(AW-DW){disp[DW-1]}}, disp} : '0;
      redir_req  <= found & taken;
    end
  end

endmodule

module static_branch_resolver_chk #(
  parameter int NENT = 8,
  parameter int AW   = 32,
  parameter int DW   = 16,
  parameter int CCN  = 4,
  localparam int IW  = $clog2(NENT),
  localparam int CSW = $clog2(CCN)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NENT-1:0]    ent_valid,
  input logic [NENT-1:0]    ent_isbr,
  input logic [NENT-1:0]    ent_cond,
  input logic [NENT*DW-1:0] ent_disp,
  input logic               cc_valid,
  input logic               dec_valid,
  input logic [IW-1:0]      dec_idx,
  input logic               dec_taken,
  input logic               dec_spec,
  input logic               redir_req
);

  logic            live;
  logic [NENT-1:0] q_hit, q_cond;
  logic [NENT*DW-1:0] q_disp;
  logic            q_ccv;
  logic [NENT-1:0] below;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= 1'b0; q_hit <= '0; q_cond <= '0; q_disp <= '0; q_ccv <= 1'b0;
    end else begin
      live <= 1'b1; q_hit <= ent_valid & ent_isbr; q_cond <= ent_cond;
      q_disp <= ent_disp; q_ccv <= cc_valid;
    end
  end

  assign below = (NENT'(1) << dec_idx) - NENT'(1);

  // R1
  oldest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && dec_valid |-> q_hit[dec_idx] && ((q_hit & below) == '0));
  // R7
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && q_hit == '0 |-> !dec_valid && !redir_req);
  // R7
  redir_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req |-> dec_valid && dec_taken);
  // R4
  uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && dec_valid && !q_cond[dec_idx] |-> dec_taken && !dec_spec);
  // R5
  known_cc_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && dec_valid && q_ccv |-> !dec_spec);
  // R6
  guess_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && dec_valid && dec_spec |-> dec_taken == q_disp[dec_idx*DW + DW-1]);

endmodule

bind static_branch_resolver static_branch_resolver_chk #(
  .NENT(NENT), .AW(AW), .DW(DW), .CCN(CCN)
) u_chk (.*);

// File: tb/tb_static_branch_resolver.sv
module tb_static_branch_resolver;
  localparam int NENT = 8, AW = 32, DW = 16, CCN = 4;
  localparam int IW = $clog2(NENT), CSW = $clog2(CCN);

  logic clk = 0, rst_n = 0;
  logic [NENT-1:0] ent_valid, ent_isbr, ent_cond, ent_sense;
  logic [NENT*CSW-1:0] ent_ccsel;
  logic [NENT*DW-1:0]  ent_disp;
  logic [NENT*AW-1:0]  ent_pc;
  logic cc_valid;
  logic [CCN-1:0] cc_val;
  logic dec_valid, dec_taken, dec_spec, redir_req;
  logic [IW-1:0] dec_idx;
  logic [AW-1:0] dec_target;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] rng = 32'h1234_5678;

  static_branch_resolver dut (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] nxt(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic rnd(output logic [31:0] v);
    rng = nxt(rng); v = rng;
  endtask

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    ent_valid = '0; ent_isbr = '0; ent_cond = '0; ent_sense = '0;
    ent_ccsel = '0; ent_disp = '0; ent_pc = '0; cc_valid = 0; cc_val = '0;
  endtask

  task automatic randomize_all();
    logic [31:0] r;
    rnd(r); ent_valid = r[7:0]; ent_isbr = r[15:8]; ent_cond = r[23:16]; ent_sense = r[31:24];
    rnd(r); ent_ccsel = r[15:0]; cc_valid = r[16]; cc_val = r[23:20];
    for (int i = 0; i < NENT; i++) begin
      rnd(r); ent_disp[i*DW +: DW] = r[DW-1:0];
      rnd(r); ent_pc[i*AW +: AW] = r;
    end
  endtask

  // Apply current inputs at a falling edge, check at the next falling edge.
  task automatic apply_check(string req);
    logic fnd, e_tk, e_sp;
    int s;
    logic [DW-1:0] d;
    logic [AW-1:0] e_tg;
    fnd = 0; s = 0;
    for (int i = NENT-1; i >= 0; i--)
      if (ent_valid[i] && ent_isbr[i]) begin fnd = 1; s = i; end
    d = ent_disp[s*DW +: DW];
    e_tg = ent_pc[s*AW +: AW] + AW'($signed(d));
    if (!ent_cond[s]) begin e_tk = 1; e_sp = 0; end
    else if (cc_valid) begin e_tk = (cc_val[ent_ccsel[s*CSW +: CSW]] == ent_sense[s]); e_sp = 0; end
    else begin e_tk = d[DW-1]; e_sp = 1; end
    @(negedge clk);
    chk({req, " valid"}, AW'(dec_valid), AW'(fnd));
    chk({req, " redirect"}, AW'(redir_req), AW'(fnd & e_tk));
    if (fnd) begin
      chk({req, " idx"}, AW'(dec_idx), AW'(s));
      chk({req, " taken"}, AW'(dec_taken), AW'(e_tk));
      chk({req, " spec"}, AW'(dec_spec), AW'(e_sp));
      chk({req, " target"}, dec_target, e_tg);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    logic [DW-1:0] dv;
    logic a_v, a_t, a_s;
    logic [AW-1:0] a_g;
    randomize_all();
    repeat (3) @(negedge clk);
    // R9: outputs at zero under reset even with branches present
    chk("R9 valid", AW'(dec_valid), 0);
    chk("R9 redirect", AW'(redir_req), 0);
    chk("R9 target", dec_target, 0);
    rst_n = 1;

    // R1 R2 R3 R4 R5 R6: every position of the oldest branch, every decision class
    for (int p = 0; p < NENT; p++) begin
      for (int m = 0; m < 6; m++) begin
        randomize_all();
        for (int i = 0; i < p; i++) begin
          ent_valid[i] = i[0];
          ent_isbr[i]  = ~i[0];
        end
        ent_valid[p] = 1; ent_isbr[p] = 1;
        ent_cond[p] = (m != 0);
        cc_valid = (m == 1 || m == 2);
        rnd(r);
        ent_sense[p] = r[0];
        cc_val[ent_ccsel[p*CSW +: CSW]] = (m == 1) ? r[0] : ~r[0];
        dv = (m == 3) ? (DW'(1) << (DW-1)) | DW'(r[14:1]) :
             (m == 4) ? DW'(r[14:1]) | DW'(1) : (m == 5) ? '0 : ent_disp[p*DW +: DW];
        ent_disp[p*DW +: DW] = dv;
        case (m)
          0: apply_check("R4 R1 R2 R3");
          1: apply_check("R5 match R1 R2");
          2: apply_check("R5 mismatch R1 R2");
          3: apply_check("R6 backward R1 R2");
          4: apply_check("R6 forward R1 R2");
          default: apply_check("R6 zero disp R3");
        endcase
      end
    end

    // R7: empty buffer, and valid non-branches only
    clear_all(); apply_check("R7 empty");
    randomize_all(); ent_isbr = '0; apply_check("R7 no branch");
    randomize_all(); ent_valid = '0; apply_check("R2 invalid branches");

    // R3: wrap of the target address past both ends
    clear_all(); ent_valid[0] = 1; ent_isbr[0] = 1;
    ent_pc[0 +: AW] = 32'h0000_0004; ent_disp[0 +: DW] = 16'hFFF0; apply_check("R3 wrap low");
    ent_pc[0 +: AW] = 32'hFFFF_FFF8; ent_disp[0 +: DW] = 16'h0010; apply_check("R3 wrap high");

    // R8: same contents give the same decision after unrelated traffic
    randomize_all(); ent_valid[3] = 1; ent_isbr[3] = 1;
    @(negedge clk); @(negedge clk);
    a_v = dec_valid; a_t = dec_taken; a_s = dec_spec; a_g = dec_target;
    begin
      logic [NENT-1:0] sv, sb, sc, ss; logic [NENT*CSW-1:0] sl;
      logic [NENT*DW-1:0] sd; logic [NENT*AW-1:0] sp; logic scv; logic [CCN-1:0] scc;
      sv = ent_valid; sb = ent_isbr; sc = ent_cond; ss = ent_sense; sl = ent_ccsel;
      sd = ent_disp; sp = ent_pc; scv = cc_valid; scc = cc_val;
      for (int k = 0; k < 20; k++) begin randomize_all(); @(negedge clk); end
      ent_valid = sv; ent_isbr = sb; ent_cond = sc; ent_sense = ss; ent_ccsel = sl;
      ent_disp = sd; ent_pc = sp; cc_valid = scv; cc_val = scc;
    end
    @(negedge clk);
    chk("R8 valid", AW'(dec_valid), AW'(a_v));
    chk("R8 taken", AW'(dec_taken), AW'(a_t));
    chk("R8 spec", AW'(dec_spec), AW'(a_s));
    chk("R8 target", dec_target, a_g);

    // R1-style random sweep over all fields
    for (int k = 0; k < 3000; k++) begin
      randomize_all();
      apply_check("R1 R5 R6 R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule